// File: doc/BRIEF.md
# System Register Access Gate

This block holds a single 64-bit configuration register and rules on every read or write request aimed at it. Each request carries the caller's privilege level (0 to 3), a read/write flag and the five encoding fields of the register-access instruction. The block checks those fields against the one encoding it owns. A request that matches gets exactly one response, one clock later. The response says whether access is granted, undefined, trapped to level 2 or trapped to level 3, and it carries a syndrome class. A request that does not match gets no response.

The ruling depends on several side inputs:

- whether the feature exists;
- whether the level-3 firmware layer exists;
- whether the fine-grained trap feature exists, and its enable;
- whether level 2 is enabled;
- the separate fine-grained read and write trap bits;
- a coarse profiling trap bit;
- a level-3 profiling-buffer trap condition;
- two secure-debug indicators, one of them a priority variant.

The checks are made in a fixed order, and that order differs between levels 1 and 2. The register changes only on a granted write. Only its three 5-bit filter fields can be written; every other bit is held at zero.

Top module: `sysreg_access_gate`

## Requirements
- R1: When feat_present is 0, every matching request gets outcome UNDEF (code 1).
- R2: A matching request from level 0 gets outcome UNDEF (code 1) whenever the feature is present.
- R3: A matching request from level 3 is always granted (code 0) when the feature is present.
- R4: At level 1 the first check is l3_present, sd_undef_prio and l3_buf_trap all being 1. When it holds, the outcome is UNDEF (code 1) no matter what the trap inputs say.
- R5: At level 1 the second check traps to level 2 (code 2). It fires when l2_enabled and fgt_present are both 1, fgt_enable is 1 (treated as 1 when l3_present is 0), and the trap bit for the access direction is 1: fg_read_trap for reads, fg_write_trap for writes.
- R6: At level 1 the third check traps to level 2 (code 2) when l2_enabled and coarse_trap are both 1.
- R7: After the earlier checks, at level 1 or 2, when l3_present and l3_buf_trap are both 1, the outcome is UNDEF (code 1) if sd_undef is 1 and a trap to level 3 (code 3) otherwise. If no check fires, access is granted.
- R8: At level 2 the fine-grained and coarse trap inputs have no effect. Only the priority-undefined check (as in R4) and the R7 check apply, in that order.
- R9: rsp_class is 0x18 for outcomes 2 and 3 and 0 for outcomes 0 and 1.
- R10: Only op0=3, op1=0, CRn=9, CRm=9 and op2=4 match. Any other encoding produces no response and leaves the register unchanged.
- R11: A granted read returns the register value on rsp_rdata. A denied response returns zero data.
- R12: A granted write loads the register. A denied write leaves it unchanged.
- R13: Only bits 52:48, 20:16 and 4:0 can be written. All other bits always read as zero.
- R14: After reset, reg_value is zero and rsp_valid is low. A response appears exactly one clock edge after the request is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_level | input | 2 | Privilege level of the caller |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_wdata | input | 64 | Write data |
| feat_present | input | 1 | Feature implemented |
| l3_present | input | 1 | Level-3 layer implemented |
| fgt_present | input | 1 | Fine-grained trap feature implemented |
| l2_enabled | input | 1 | Level 2 enabled |
| fgt_enable | input | 1 | Fine-grained trap enable from level 3 |
| fg_read_trap | input | 1 | Fine-grained trap bit for reads |
| fg_write_trap | input | 1 | Fine-grained trap bit for writes |
| coarse_trap | input | 1 | Coarse profiling trap bit at level 2 |
| l3_buf_trap | input | 1 | Level-3 profiling-buffer trap condition |
| sd_undef | input | 1 | Secure debug disabled: level-3 trap becomes undefined |
| sd_undef_prio | input | 1 | Secure debug disabled, priority form |
| rsp_valid | output | 1 | Response strobe |
| rsp_outcome | output | 2 | 0 grant, 1 undefined, 2 trap level 2, 3 trap level 3 |
| rsp_class | output | 6 | Syndrome exception class |
| rsp_rdata | output | 64 | Read data (zero unless a read is granted) |
| reg_value | output | 64 | Current register contents |

## Verification
Every output that results from a request is due at the first rising edge after the request is driven. This covers the outcome, the class, the read data and the register update. The bench drives on the falling edge and compares on the next falling edge, so each comparison sits exactly one register stage after its stimulus. A behavioural model predicts the outcome, class, data and register value for that edge. Idle cycles and non-matching encodings are also compared, against an expected low rsp_valid and an unchanged register.

// File: rtl/sra_pkg.sv
package sra_pkg;
    localparam int DATA_W  = 64;
    localparam int CLASS_W = 6;

    typedef enum logic [1:0] {
        OUT_GRANT   = 2'd0,
        OUT_UNDEF   = 2'd1,
        OUT_TRAP_L2 = 2'd2,
        OUT_TRAP_L3 = 2'd3
    } outcome_e;

    localparam logic [DATA_W-1:0]  KEEP_MASK  = 64'h001F_0000_001F_001F;
    localparam logic [CLASS_W-1:0] TRAP_CLASS = 6'h18;

    typedef struct packed {
        logic feat;
        logic l3;
        logic fgt;
        logic l2en;
        logic fgt_en;
        logic fg_rd;
        logic fg_wr;
        logic coarse;
        logic buf_trap;
        logic sd_undef;
        logic sd_prio;
    } ctl_t;

    typedef struct packed {
        outcome_e            outcome;
        logic [CLASS_W-1:0]  cls;
    } verdict_t;

    function automatic logic is_trap(outcome_e o);
        return (o == OUT_TRAP_L2) || (o == OUT_TRAP_L3);
    endfunction
endpackage

// File: rtl/sra_match.sv
module sra_match #(
    parameter logic [1:0] OP0 = 2'b11,
    parameter logic [2:0] OP1 = 3'b000,
    parameter logic [3:0] CRN = 4'b1001,
    parameter logic [3:0] CRM = 4'b1001,
    parameter logic [2:0] OP2 = 3'b100
) (
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       hit
);
    assign hit = (op0 == OP0) && (op1 == OP1) && (crn == CRN) &&
                 (crm == CRM) && (op2 == OP2);
endmodule

// File: rtl/sra_decide.sv
module sra_decide
    import sra_pkg::*;
(
    input  logic [1:0] level,
    input  logic       write,
    input  ctl_t       ctl,
    output verdict_t   verdict
);
    logic prio_undef, l3_cond, fg_bit, fg_fire, coarse_fire;
    outcome_e l3_result, res;

    always_comb begin
        prio_undef  = ctl.l3 && ctl.sd_prio && ctl.buf_trap;
        l3_cond     = ctl.l3 && ctl.buf_trap;
        fg_bit      = write ? ctl.fg_wr : ctl.fg_rd;
        fg_fire     = ctl.l2en && ctl.fgt && (!ctl.l3 || ctl.fgt_en) && fg_bit;
        coarse_fire = ctl.l2en && ctl.coarse;
        l3_result   = ctl.sd_undef ? OUT_UNDEF : OUT_TRAP_L3;

        res = OUT_GRANT;
        if (!ctl.feat) begin
            res = OUT_UNDEF;
        end else begin
            unique case (level)
                2'd0: res = OUT_UNDEF;
                2'd1: begin
                    if (prio_undef)       res = OUT_UNDEF;
                    else if (fg_fire)     res = OUT_TRAP_L2;
                    else if (coarse_fire) res = OUT_TRAP_L2;
                    else if (l3_cond)     res = l3_result;
                    else                  res = OUT_GRANT;
                end
                2'd2: begin
                    if (prio_undef)       res = OUT_UNDEF;
                    else if (l3_cond)     res = l3_result;
                    else                  res = OUT_GRANT;
                end
                default: res = OUT_GRANT;
            endcase
        end
        verdict.outcome = res;
        verdict.cls     = is_trap(res) ? TRAP_CLASS : '0;
    end
endmodule

// File: rtl/sra_store.sv
module sra_store #(
    parameter int               W    = 64,
    parameter logic [W-1:0]     MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_live
            always_ff @(posedge clk) begin
                if (rst)        q[i] <= 1'b0;
                else if (wr_en) q[i] <= wdata[i];
            end
        end else begin : g_tied
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/sysreg_access_gate.sv
module sysreg_access_gate
    import sra_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [1:0]          req_level,
    input  logic [1:0]          req_op0,
    input  logic [2:0]          req_op1,
    input  logic [3:0]          req_crn,
    input  logic [3:0]          req_crm,
    input  logic [2:0]          req_op2,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                feat_present,
    input  logic                l3_present,
    input  logic                fgt_present,
    input  logic                l2_enabled,
    input  logic                fgt_enable,
    input  logic                fg_read_trap,
    input  logic                fg_write_trap,
    input  logic                coarse_trap,
    input  logic                l3_buf_trap,
    input  logic                sd_undef,
    input  logic                sd_undef_prio,
    output logic                rsp_valid,
    output logic [1:0]          rsp_outcome,
    output logic [CLASS_W-1:0]  rsp_class,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [DATA_W-1:0]   reg_value
);
    logic     hit, take, grant;
    ctl_t     ctl;
    verdict_t verdict;

    assign ctl = '{feat: feat_present, l3: l3_present, fgt: fgt_present,
                   l2en: l2_enabled, fgt_en: fgt_enable, fg_rd: fg_read_trap,
                   fg_wr: fg_write_trap, coarse: coarse_trap,
                   buf_trap: l3_buf_trap, sd_undef: sd_undef,
                   sd_prio: sd_undef_prio};

    sra_match u_match (
        .op0(req_op0), .op1(req_op1), .crn(req_crn),
        .crm(req_crm), .op2(req_op2), .hit(hit)
    );

    sra_decide u_decide (
        .level(req_level), .write(req_write), .ctl(ctl), .verdict(verdict)
    );

    assign take  = req_valid && hit;
    assign grant = take && (verdict.outcome == OUT_GRANT);

    sra_store #(.W(DATA_W), .MASK(KEEP_MASK)) u_store (
        .clk(clk), .rst(rst), .wr_en(grant && req_write),
        .wdata(req_wdata), .q(reg_value)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_outcome <= OUT_GRANT;
            rsp_class   <= '0;
            rsp_rdata   <= '0;
        end else begin
            rsp_valid   <= take;
            rsp_outcome <= take ? verdict.outcome : OUT_GRANT;
            rsp_class   <= take ? verdict.cls : '0;
            rsp_rdata   <= (grant && !req_write) ? reg_value : '0;
        end
    end
endmodule

// File: rtl/sra_checker.sv
module sra_checker
    import sra_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_write,
    input logic [1:0]          req_level,
    input logic [1:0]          req_op0,
    input logic [2:0]          req_op1,
    input logic [3:0]          req_crn,
    input logic [3:0]          req_crm,
    input logic [2:0]          req_op2,
    input logic                feat_present,
    input logic                rsp_valid,
    input logic [1:0]          rsp_outcome,
    input logic [CLASS_W-1:0]  rsp_class,
    input logic [DATA_W-1:0]   rsp_rdata,
    input logic [DATA_W-1:0]   reg_value
);
    logic enc_ok;
    assign enc_ok = (req_op0 == 2'b11) && (req_op1 == 3'b000) &&
                    (req_crn == 4'b1001) && (req_crm == 4'b1001) &&
                    (req_op2 == 3'b100);

    p_absent_undef_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && enc_ok && !feat_present) |=> (rsp_outcome == 2'd1));

    p_level0_undef_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && enc_ok && req_level == 2'd0) |=> (rsp_outcome == 2'd1));

    p_level3_grant_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && enc_ok && feat_present && req_level == 2'd3)
        |=> (rsp_outcome == 2'd0));

    p_trap_class_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_class == ((rsp_outcome[1]) ? 6'h18 : 6'h00)));

    p_no_match_silent_r10: assert property (@(posedge clk) disable iff (rst)
        (!(req_valid && enc_ok)) |=> (!rsp_valid && $stable(reg_value)));

    p_denied_zero_data_r11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_outcome != 2'd0) |-> (rsp_rdata == '0));

    p_denied_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && enc_ok && req_write) ##1 (rsp_outcome != 2'd0)
        |-> $stable(reg_value));

    p_reserved_zero_r13: assert property (@(posedge clk) disable iff (rst)
        (reg_value & ~KEEP_MASK) == '0);

    p_one_cycle_r14: assert property (@(posedge clk) disable iff (rst)
        (req_valid && enc_ok) |=> rsp_valid);
endmodule

bind sysreg_access_gate sra_checker u_chk (.*);

// File: tb/sysreg_access_gate_tb_top.sv
module sysreg_access_gate_tb_top;
    localparam int  CLK_PERIOD = 10;
    localparam logic [63:0] WMASK = 64'h001F_0000_001F_001F;

    logic clk = 1'b0;
    logic rst;
    logic req_valid, req_write;
    logic [1:0] req_level, req_op0;
    logic [2:0] req_op1, req_op2;
    logic [3:0] req_crn, req_crm;
    logic [63:0] req_wdata;
    logic feat_present, l3_present, fgt_present, l2_enabled, fgt_enable;
    logic fg_read_trap, fg_write_trap, coarse_trap, l3_buf_trap, sd_undef, sd_undef_prio;
    logic rsp_valid;
    logic [1:0] rsp_outcome;
    logic [5:0] rsp_class;
    logic [63:0] rsp_rdata, reg_value;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [63:0] model_reg;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysreg_access_gate dut_i (.*);

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // behavioural model: returns outcome code and the requirement that decided it
    function automatic int predict(output string tag);
        bit fgbit;
        fgbit = req_write ? fg_write_trap : fg_read_trap;
        if (!feat_present) begin tag = "R1"; return 1; end
        if (req_level == 0) begin tag = "R2"; return 1; end
        if (req_level == 3) begin tag = "R3"; return 0; end
        if (l3_present && sd_undef_prio && l3_buf_trap) begin
            tag = (req_level == 1) ? "R4" : "R8"; return 1;
        end
        if (req_level == 1) begin
            if (l2_enabled && fgt_present && fgbit && (fgt_enable || !l3_present)) begin
                tag = "R5"; return 2;
            end
            if (l2_enabled && coarse_trap) begin tag = "R6"; return 2; end
        end
        if (l3_present && l3_buf_trap) begin tag = "R7"; return sd_undef ? 1 : 3; end
        tag = (req_level == 2) ? "R8" : "R7";
        return 0;
    endfunction

    // drive at negedge, compare at the following negedge (one edge later)
    task automatic step();
        bit hitx;
        int oc;
        string tag;
        logic [63:0] exp_data;
        hitx = req_valid && req_op0 == 2'd3 && req_op1 == 3'd0 && req_crn == 4'd9 &&
               req_crm == 4'd9 && req_op2 == 3'd4;
        oc = predict(tag);
        exp_data = '0;
        if (hitx && oc == 0 && !req_write) exp_data = model_reg;
        @(posedge clk);
        @(negedge clk);
        if (!hitx) begin
            check("R10", "rsp_valid", {63'd0, rsp_valid}, 64'd0);
            check("R10", "reg_value", reg_value, model_reg);
        end else begin
            if (oc == 0 && req_write) model_reg = req_wdata & WMASK;
            check("R14", "rsp_valid", {63'd0, rsp_valid}, 64'd1);
            check(tag, "outcome", {62'd0, rsp_outcome}, 64'(oc));
            check("R9", "class", {58'd0, rsp_class}, (oc >= 2) ? 64'h18 : 64'h0);
            check("R11", "rdata", rsp_rdata, exp_data);
            check(req_write ? "R12" : "R11", "reg_value", reg_value, model_reg);
            check("R13", "reserved", reg_value & ~WMASK, 64'd0);
        end
    endtask

    task automatic ctl(bit f, bit l3, bit fg, bit l2, bit fen, bit frd, bit fwr,
                       bit co, bit bt, bit sd, bit sp);
        feat_present = f; l3_present = l3; fgt_present = fg; l2_enabled = l2;
        fgt_enable = fen; fg_read_trap = frd; fg_write_trap = fwr; coarse_trap = co;
        l3_buf_trap = bt; sd_undef = sd; sd_undef_prio = sp;
    endtask

    task automatic req(bit wr, logic [1:0] lvl, logic [63:0] d);
        req_valid = 1; req_write = wr; req_level = lvl; req_wdata = d;
        req_op0 = 2'd3; req_op1 = 3'd0; req_crn = 4'd9; req_crm = 4'd9; req_op2 = 3'd4;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; req_valid = 0; req_write = 0; req_level = 0; req_wdata = '0;
        req_op0 = 0; req_op1 = 0; req_crn = 0; req_crm = 0; req_op2 = 0;
        ctl(1,0,0,0,0,0,0,0,0,0,0);
        model_reg = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        check("R14", "reset reg", reg_value, 64'd0);
        check("R14", "reset valid", {63'd0, rsp_valid}, 64'd0);

        req(1, 3, 64'hFFFF_FFFF_FFFF_FFFF);       // R3, R13 all ones
        req(0, 3, 0);                             // R11 read back
        ctl(0,1,1,1,1,0,0,0,0,0,0); req(1, 3, 64'h1); // R1
        ctl(1,0,0,0,0,0,0,0,0,0,0); req(1, 0, 64'h2); // R2
        ctl(1,1,1,1,1,1,1,1,1,0,1); req(1, 1, 64'h3); // R4
        ctl(1,1,1,1,1,1,0,1,1,0,0); req(0, 1, 0);     // R5 read bit
        ctl(1,1,1,1,1,0,1,0,0,0,0); req(0, 1, 0);     // R5 read ignores write bit -> grant
        ctl(1,0,1,1,0,0,1,0,0,0,0); req(1, 1, 64'h5); // R5 enable forced without l3
        ctl(1,1,1,1,0,0,1,1,0,0,0); req(1, 1, 64'h6); // R6
        ctl(1,1,0,0,0,0,0,0,1,0,0); req(1, 1, 64'h7); // R7 trap l3
        ctl(1,1,0,0,0,0,0,0,1,1,0); req(1, 2, 64'h8); // R7 undef
        ctl(1,1,1,1,1,1,1,1,0,0,0); req(1, 2, 64'h0012_0000_0011_0009); // R8 grant
        ctl(1,1,1,1,1,1,1,1,1,0,1); req(0, 2, 0);     // R8 priority undef
        ctl(1,0,0,0,0,0,0,0,0,0,0); req(0, 1, 0);     // grant read
        req_valid = 1; req_write = 1; req_op2 = 3'd5; req_wdata = '1; step(); // R10
        req_valid = 0; step();

        for (int i = 0; i < 600; i++) begin
            ctl($urandom%2 == 0 ? 1 : $urandom%2, $urandom%2, $urandom%2, $urandom%2,
                $urandom%2, $urandom%2, $urandom%2, $urandom%2, $urandom%2,
                $urandom%2, $urandom%2);
            req_valid = ($urandom % 8) != 0;
            req_write = $urandom % 2;
            req_level = 2'($urandom);
            req_wdata = {$urandom, $urandom};
            req_op0 = 2'd3; req_op1 = 3'd0; req_crn = 4'd9; req_crm = 4'd9; req_op2 = 3'd4;
            if (($urandom % 6) == 0) req_crm = 4'($urandom);
            step();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule